// File: doc/BRIEF.md
# Stepped Counter with Hex Digit Display

This block holds a 6-bit count that changes on every rising clock edge by a 4-bit step taken from a bank of switches, in place of the usual fixed increment of one. The step is read as a signed two's-complement value. Small positive settings make the count rise by that amount each cycle. A setting of zero freezes it. Settings with the top bit set make it fall. All arithmetic wraps modulo 64.

The low four bits of the count drive one seven-segment digit, shown as a hex character 0 to F. The digit is a common-anode part, so a segment lights when its output is low. The segment outputs come from a register. They follow the count one clock later and cannot glitch while the count changes. The raw count is also brought out as a bus. Switch debouncing and multi-digit scanning belong to the surrounding logic.

Top module: `stride_counter_display`

## Requirements
- R1: A rising clock edge with `rst_n` low sets `count_o` to 0 and `seg_n_o` to the active-low pattern of digit 0 (7'h40).
- R2: On each rising edge with `rst_n` high, `count_o` becomes the old count plus `step_i` sign-extended from 4 bits, modulo 64.
- R3: A step of 4'h0 leaves `count_o` unchanged at every edge.
- R4: Steps of 4'h1, 4'h2 and 4'h3 raise the count by 1, 2 and 3 per edge.
- R5: Step 4'hF lowers the count by one per edge and step 4'hE lowers it by two. Going below zero wraps, so 0 with step 4'hF gives 63.
- R6: Going above 63 wraps to the low end, so 63 with step 4'h1 gives 0.
- R7: `seg_n_o` bit 0 is segment a, bit 1 is b and so on through bit 6, which is g. A segment is lit when its bit is 0. For the hex digits 0 to F, the active-high lit patterns are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F, 77, 7C, 39, 5E, 79, 71. `seg_n_o` is the bitwise inverse of the pattern for `count_o[3:0]`.
- R8: `seg_n_o` is registered. After each edge it shows the digit for the count as it stood just before that edge, one clock behind `count_o`. At least two segments are always lit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_i | input | 4 | Signed step added to the count each cycle |
| count_o | output | 6 | Current count |
| seg_n_o | output | 7 | Segments a..g (bit 0..6), active low |

## Verification
The assertions assume that `step_i` is settled before each rising edge and changes only between edges. They also assume that `rst_n` is low on the first edge, so that the count starts from a known value. The bench meets both assumptions:
- It changes `step_i` and `rst_n` only on falling edges.
- It holds reset low for several edges before releasing it.

Debounced switches in the target system are what keep `step_i` settled.

// File: rtl/stride_pkg.sv
`timescale 1ns / 1ps
// Package stride_pkg
// Holds the shared widths and the hex-to-segment pattern function.
// Assumes one digit of seven segments, bit 0 = a ... bit 6 = g.
package stride_pkg;
    localparam int SEG_N   = 7;
    localparam int NIBBLE  = 4;

    // Return the active-high lit pattern for a hex nibble.
    function automatic logic [SEG_N-1:0] hex_lit(input logic [NIBBLE-1:0] v);
        logic [SEG_N-1:0] p;
        case (v)
            4'h0: p = 7'h3F;
            4'h1: p = 7'h06;
            4'h2: p = 7'h5B;
            4'h3: p = 7'h4F;
            4'h4: p = 7'h66;
            4'h5: p = 7'h6D;
            4'h6: p = 7'h7D;
            4'h7: p = 7'h07;
            4'h8: p = 7'h7F;
            4'h9: p = 7'h6F;
            4'hA: p = 7'h77;
            4'hB: p = 7'h7C;
            4'hC: p = 7'h39;
            4'hD: p = 7'h5E;
            4'hE: p = 7'h79;
            default: p = 7'h71;
        endcase
        return p;
    endfunction
endpackage

// File: rtl/stride_accum.sv
`timescale 1ns / 1ps
// Module stride_accum
// Keeps a CNT_W-bit count that adds an extended step on each rising edge.
// STEP_SIGNED picks sign extension (1) or zero extension (0) of the step.
// Assumes CNT_W > STEP_W and that step_i is settled before each edge.
module stride_accum #(
    parameter int CNT_W       = 6,
    parameter int STEP_W      = 4,
    parameter bit STEP_SIGNED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STEP_W-1:0] step_i,
    output logic [CNT_W-1:0]  count_o
);
    localparam int PAD_W = CNT_W - STEP_W;

    logic [CNT_W-1:0] step_ext;
    logic [CNT_W-1:0] count_q;

    // Widen the step to the count width.
    generate
        if (STEP_SIGNED) begin : g_sext
            assign step_ext = {{PAD_W{step_i[STEP_W-1]}}, step_i};
        end else begin : g_zext
            assign step_ext = {{PAD_W{1'b0}}, step_i};
        end
    endgenerate

    // Count register: clear on reset, otherwise add the step modulo 2**CNT_W.
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_q + step_ext;
    end

    assign count_o = count_q;

    // R3: a zero step freezes the count.
    a_r3_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == '0) |=> $stable(count_q));

    // R4: a step of one raises the count by exactly one.
    a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == STEP_W'(1)) |=> (count_q == $past(count_q) + 1'b1));

    // R5: the all-ones step lowers the count by one (signed variant only).
    a_r5_down_one: assert property (@(posedge clk) disable iff (!rst_n)
        (STEP_SIGNED && step_i == '1) |=> (count_q == $past(count_q) - 1'b1));

    // R6: the top value plus one wraps to zero.
    a_r6_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == '1 && step_i == STEP_W'(1)) |=> (count_q == '0));
endmodule

// File: rtl/hex_seg_decode.sv
`timescale 1ns / 1ps
// Module hex_seg_decode
// Combinational hex-to-segment decoder with active-low outputs for a common-anode digit.
// Assumes the segment order bit 0 = a ... bit 6 = g.
module hex_seg_decode
    import stride_pkg::*;
(
    input  logic [NIBBLE-1:0] nib_i,
    output logic [SEG_N-1:0]  seg_n_o
);
    // Invert the lit pattern because a segment lights on a low level.
    always_comb seg_n_o = ~hex_lit(nib_i);
endmodule

// File: rtl/seg_hold_reg.sv
`timescale 1ns / 1ps
// Module seg_hold_reg
// Registers the segment drive so that the pins change only on a clock edge.
// On reset it loads RST_VAL, which is the blank-free pattern for digit 0.
module seg_hold_reg #(
    parameter int             W       = 7,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    // Segment pipeline register.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= RST_VAL;
        else        q_o <= d_i;
    end
endmodule

// File: rtl/stride_counter_display.sv
`timescale 1ns / 1ps
// Module stride_counter_display
// Switch-stepped counter with one hex digit on a common-anode seven-segment display.
// The segments come from a register and trail the count by one clock.
// Assumes step_i is debounced and rst_n is low on the first edge.
module stride_counter_display
    import stride_pkg::*;
#(
    parameter int CNT_W  = 6,
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STEP_W-1:0] step_i,
    output logic [CNT_W-1:0]  count_o,
    output logic [SEG_N-1:0]  seg_n_o
);
    localparam logic [SEG_N-1:0] ZERO_N = ~hex_lit(4'h0);

    logic [CNT_W-1:0] count_w;
    logic [SEG_N-1:0] seg_next;

    stride_accum #(
        .CNT_W(CNT_W), .STEP_W(STEP_W), .STEP_SIGNED(1'b1)
    ) u_accum (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .count_o(count_w)
    );

    hex_seg_decode u_dec (
        .nib_i(count_w[NIBBLE-1:0]), .seg_n_o(seg_next)
    );

    seg_hold_reg #(
        .W(SEG_N), .RST_VAL(ZERO_N)
    ) u_segq (
        .clk(clk), .rst_n(rst_n), .d_i(seg_next), .q_o(seg_n_o)
    );

    assign count_o = count_w;

    // R1: a reset edge clears the count and shows digit 0.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (count_o == '0 && seg_n_o == 7'h40));

    // R8: if the shown nibble did not change, the segments do not change next edge.
    a_r8_seg_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o[NIBBLE-1:0] == $past(count_o[NIBBLE-1:0])) |=> $stable(seg_n_o));

    // R8: every hex glyph lights at least two segments.
    a_r8_some_lit: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~seg_n_o) >= 2);
endmodule

// File: tb/stride_counter_display_tb.sv
`timescale 1ns / 1ps
module stride_counter_display_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] step_i = 4'h0;
    logic [5:0] count_o;
    logic [6:0] seg_n_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [5:0] model = '0;

    // Each entry: step in [7:4], number of edges in [3:0].
    localparam int NV = 9;
    localparam logic [7:0] VEC [NV] = '{
        8'h15, 8'h24, 8'h34, 8'h03, 8'hF6, 8'hE5, 8'h7A, 8'h83, 8'h12
    };

    stride_counter_display u_dut (
        .clk(clk), .rst_n(rst_n), .step_i(step_i),
        .count_o(count_o), .seg_n_o(seg_n_o)
    );

    always #5 clk = ~clk;

    function automatic logic [6:0] lit(input logic [3:0] v);
        logic [6:0] t [16];
        t = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
              7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
        return t[v];
    endfunction

    task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one step for one edge, then check count (R2) and lagging segments (R7/R8).
    task automatic run_edge(input logic [3:0] s, input string req);
        logic [5:0] prev;
        prev = model;
        step_i = s;
        model = model + {{2{s[3]}}, s};
        @(posedge clk);
        @(negedge clk);
        chk(req, {1'b0, count_o}, {1'b0, model});
        chk("R7/R8 seg lag", seg_n_o, ~lit(prev[3:0]));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model = '0;
    endtask

    initial begin
        @(negedge clk);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 count", {1'b0, count_o}, 7'h00);
        chk("R1 seg", seg_n_o, 7'h40);
        rst_n = 1'b1;

        foreach (VEC[i]) begin
            for (int k = 0; k < int'(VEC[i][3:0]); k++) begin
                case (VEC[i][7:4])
                    4'h0:       run_edge(VEC[i][7:4], "R3 zero holds");
                    4'h1, 4'h2,
                    4'h3:       run_edge(VEC[i][7:4], "R4 up count");
                    4'hF, 4'hE: run_edge(VEC[i][7:4], "R5 down count");
                    default:    run_edge(VEC[i][7:4], "R2 signed add");
                endcase
            end
        end

        // R1: reset in mid-run with a nonzero step
        step_i = 4'h5;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 mid reset count", {1'b0, count_o}, 7'h00);
        chk("R1 mid reset seg", seg_n_o, 7'h40);
        rst_n = 1'b1;
        model = '0;

        // R5: below zero wraps to 63
        run_edge(4'hF, "R5 wrap below zero");
        chk("R5 wrap value", {1'b0, count_o}, 7'h3F);
        // R6: 63 plus one wraps to 0
        run_edge(4'h1, "R6 wrap above top");
        chk("R6 wrap value", {1'b0, count_o}, 7'h00);

        // R7: walk every nibble value through the display
        do_reset();
        for (int n = 0; n < 17; n++) run_edge(4'h1, "R7 all digits");

        // R3: a long hold with a zero step
        for (int n = 0; n < 4; n++) run_edge(4'h0, "R3 long hold");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule